// File: doc/BRIEF.md
# Sequential Radix-4 Multiplier with Carry-Recoded Digits

This block multiplies an unsigned multiplicand by an unsigned multiplier, retiring two multiplier bits per clock. The hard multiple three times the multiplicand is never formed. Each two-bit digit is first added to a carry flag left over from the previous digit. An effective digit of 3 becomes "subtract the multiplicand and carry one upward". An effective digit of 4 becomes "add nothing and carry one upward". The adder therefore only ever sees zero, the multiplicand, the multiplicand shifted left once, or the multiplicand's two's complement.

The upper half of the running sum is a signed register, because subtracting can push it briefly below zero. After each addition it is shifted right arithmetically by two places. The two bits that fall out are collected into a lower register that becomes the low end of the product. If a carry is still pending after the top digit, one more cycle adds the multiplicand at the next digit weight.

A one-cycle `start` strobe, given while the block is idle, captures both operands. A one-cycle `done` pulse marks the cycle in which `product` first shows the result. The product then stays fixed until a later run completes.

Top module: `radix4_recode_mul`

## Requirements
- R1: When `done` is high, `product` equals the unsigned product `a * x` of the operands captured at the accepted `start`.
- R2: `done` is high for exactly one cycle per run. `product` changes only in a cycle where `done` is high, and otherwise keeps its last value.
- R3: Let D be the number of two-bit digits of `x` (default 3). `done` rises D clock edges after the edge that accepts `start`, or D+1 edges if a carry is still pending after the top digit. The carry out of digit i is 1 when bits [2i+1:2i] of `x` plus the incoming carry is 3 or more, and the carry into digit 0 is 0.
- R4: An effective digit of 0, 1 or 2 adds 0, a or 2a with no outgoing carry. A value of 3 adds the two's complement of a and sets the carry. A value of 4 adds 0 and sets the carry.
- R5: A `start` pulse that arrives while a run is in progress is ignored. The run completes with its original operands and latency.
- R6: After reset `product` is 0 and `done` is 0. A reset during a run abandons it, and no `done` follows.
- R7: The upper partial product stays within plus or minus a throughout a run, and it is non-negative when the result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when the block is idle |
| a | input | A_W (8) | Multiplicand, unsigned |
| x | input | X_W (6) | Multiplier, unsigned |
| product | output | A_W+X_W (14) | Result, held between runs |
| done | output | 1 | One-cycle pulse when `product` is updated |

## Verification
The bench builds the block with its default widths: an 8-bit multiplicand and a 6-bit multiplier, which gives three digits. At that size all 16384 operand pairs can be run, so every chain of carries across the three digits is checked against the true product. This includes chains that end in the extra cycle and chains in which an effective digit of 4 passes the carry onward. A small table of chosen pairs pins down both latencies by name. Directed runs then cover a stray start during a run and a reset in the middle of one.

// File: rtl/radix4_recode_mul.sv
module radix4_recode_mul #(
  parameter int A_W = 8,
  parameter int X_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [A_W-1:0]     a,
  input  logic [X_W-1:0]     x,
  output logic [A_W+X_W-1:0] product,
  output logic               done
);
  localparam int ND = (X_W + 1) / 2;
  localparam int LW = 2 * ND;
  localparam int HW = A_W + 3;
  localparam int CW = $clog2(ND + 1);
  localparam int PW = A_W + X_W;

  logic          busy, fix, cy;
  logic [CW-1:0] cnt;
  logic [A_W-1:0] ar;
  logic [LW-1:0] xr, lo;
  logic [HW-1:0] hi;

  logic [2:0]    eff;
  logic          sel_a, sel_2a, sel_n, cy_n, last;
  logic [HW-1:0] a_ext, mult, sum, sum_sh, fix_sum;
  logic [HW+LW-1:0] fin_step, fin_fix;

  assign eff     = {1'b0, xr[1:0]} + {2'b0, cy};
  assign sel_a   = (eff == 3'd1);
  assign sel_2a  = (eff == 3'd2);
  assign sel_n   = (eff == 3'd3);
  assign cy_n    = (eff >= 3'd3);
  assign a_ext   = {3'b0, ar};
  assign mult    = sel_a ? a_ext : sel_2a ? (a_ext << 1) : sel_n ? ~a_ext : '0;
  assign sum     = hi + mult + {{(HW-1){1'b0}}, sel_n};
  assign sum_sh  = HW'($signed(sum) >>> 2);
  assign fix_sum = hi + a_ext;
  assign last    = (cnt == CW'(ND - 1));
  assign fin_step = {sum_sh, sum[1:0], lo[LW-1:2]};
  assign fin_fix  = {fix_sum, lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fix <= 1'b0; cy <= 1'b0; cnt <= '0;
      ar <= '0; xr <= '0; lo <= '0; hi <= '0;
      product <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy && !fix) begin
        ar <= a; xr <= LW'(x); hi <= '0; lo <= '0;
        cy <= 1'b0; cnt <= '0; busy <= 1'b1;
      end else if (busy) begin
        hi  <= sum_sh;
        lo  <= {sum[1:0], lo[LW-1:2]};
        xr  <= xr >> 2;
        cy  <= cy_n;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          if (cy_n) fix <= 1'b1;
          else begin
            done <= 1'b1;
            product <= fin_step[PW-1:0];
          end
        end
      end else if (fix) begin
        hi <= fix_sum; fix <= 1'b0; cy <= 1'b0;
        done <= 1'b1;
        product <= fin_fix[PW-1:0];
      end
    end
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);
  a_r3_fix_single: assert property (@(posedge clk) disable iff (!rst_n)
    fix |=> (!fix && done));
  a_r4_carry_multiple: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cy_n) |-> (mult == ~a_ext || mult == '0));
  a_r5_ops_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (ar == $past(ar)));
  a_r7_hi_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($signed(hi) <= $signed(a_ext) && $signed(hi) >= -$signed(a_ext)));
  a_r7_final_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hi[HW-1]);
endmodule

// File: tb/sim_radix4_recode_mul.sv
module sim_radix4_recode_mul;
  localparam int A_W = 8, X_W = 6, ND = 3, PW = A_W + X_W;
  logic clk = 0, rst_n = 0, start = 0;
  logic [A_W-1:0] a = '0;
  logic [X_W-1:0] x = '0;
  logic [PW-1:0] product;
  logic done;
  int checks = 0, fails = 0;

  radix4_recode_mul #(.A_W(A_W), .X_W(X_W)) u0 (.*);
  always #5 clk = ~clk;

  // {a, x, product, latency}
  localparam logic [30:0] VEC [12] = '{
    {8'd0,   6'd0,  14'd0,     3'd3}, {8'd0,   6'd63, 14'd0,     3'd4},
    {8'd1,   6'd1,  14'd1,     3'd3}, {8'd255, 6'd63, 14'd16065, 3'd4},
    {8'd200, 6'd3,  14'd600,   3'd3}, {8'd77,  6'd2,  14'd154,   3'd3},
    {8'd123, 6'd60, 14'd7380,  3'd4}, {8'd17,  6'd48, 14'd816,   3'd4},
    {8'd99,  6'd15, 14'd1485,  3'd3}, {8'd128, 6'd42, 14'd5376,  3'd3},
    {8'd5,   6'd44, 14'd220,   3'd4}, {8'd250, 6'd27, 14'd6750,  3'd3}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [X_W-1:0] m);
    int c = 0;
    for (int i = 0; i < ND; i++) c = ((int'(m[2*i +: 2]) + c) >= 3) ? 1 : 0;
    return ND + c;
  endfunction

  task automatic run(input logic [A_W-1:0] ia, input logic [X_W-1:0] ix,
                     input bit poke, output logic [PW-1:0] p, output int lat);
    @(negedge clk); a = ia; x = ix; start = 1;
    @(negedge clk); start = 0;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      if (poke && k == 1) begin a = ~ia; x = ~ix; start = 1; end
      else start = 0;
      @(negedge clk); lat++;
      if (done) break;
    end
    start = 0;
    p = product;
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [PW-1:0] p, prev;
    int lat;
    repeat (3) @(negedge clk);
    chk(product == 0, "R6 reset product", product, 0);
    chk(done == 0, "R6 reset done", done, 0);
    rst_n = 1;

    for (int i = 0; i < 12; i++) begin
      run(VEC[i][30:23], VEC[i][22:17], 0, p, lat);
      chk(p == VEC[i][16:3], "R1 table product", p, VEC[i][16:3]);
      chk(lat == VEC[i][2:0], "R3 R4 table latency", lat, VEC[i][2:0]);
    end

    // R2: done lasts one cycle, product held afterwards
    run(8'd211, 6'd57, 0, p, lat);
    prev = product;
    @(negedge clk);
    chk(done == 0, "R2 done pulse width", done, 0);
    repeat (5) @(negedge clk);
    chk(product == prev, "R2 product held", product, prev);

    // R5: stray start during a run
    run(8'd183, 6'd39, 1, p, lat);
    chk(p == 14'(183 * 39), "R5 start ignored product", p, 183 * 39);
    chk(lat == exp_lat(6'd39), "R5 start ignored latency", lat, exp_lat(6'd39));
    repeat (6) @(negedge clk);
    chk(product == p, "R5 no second run", product, p);

    // R6: reset mid-run
    @(negedge clk); a = 8'd99; x = 6'd63; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(product == 0, "R6 mid-run reset product", product, 0);
    rst_n = 1;
    begin
      bit seen = 0;
      repeat (6) begin @(negedge clk); if (done) seen = 1; end
      chk(!seen, "R6 no done after reset", seen, 0);
    end

    // R1 R3 R4 R7 exhaustive sweep
    for (int ia = 0; ia < 256; ia++)
      for (int ix = 0; ix < 64; ix++) begin
        run(A_W'(ia), X_W'(ix), 0, p, lat);
        chk(p == PW'(ia * ix), "R1 sweep product", p, ia * ix);
        chk(lat == exp_lat(X_W'(ix)), "R3 sweep latency", lat, exp_lat(X_W'(ix)));
      end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule